// File: doc/BRIEF.md
# Twelve-Channel Shared-Period PWM Controller

This block drives twelve pulse-width modulated outputs from one common period. Software programs a half-period value, a per-channel duty value and a per-channel enable bit through a 32-bit register port with byte addresses. Each output is center-aligned. The high part of every cycle sits symmetrically around the middle of the period, and its length in time units is set by that channel's duty value. The time unit is one `tick` clock-enable pulse.

Writes land in shadow registers only. Software then sets commit bits in the configuration register: one bit for the enable word, one for the half-period, and one per channel duty. A pending commit is copied into the live generator at the next period boundary, and the hardware then clears the commit bit. Because of this, a running output never sees a shortened or split cycle. Checking that the programmed values are in range is the job of software.

The timebase is a two-state sweep machine. In `ST_RISE` the count climbs from 0 to half−1. The transition RISE→FALL is taken on the tick where the count is half−1, and the count holds there. In `ST_FALL` the count descends to 0. The transition FALL→RISE is taken on the tick where the count is 0, and that tick is the period boundary.

Top module: `pwm12_ctrl`

## Requirements
- R1: After reset:
  - the enable word reads 0;
  - every duty register reads 0;
  - the configuration register reads 0;
  - the half-period register reads the parameter `HALF_RST` (default 5000);
  - every output is low.
- R2: Registers are addressed by byte address:
  - 0x00 is the configuration register;
  - 0x08 is the enable word;
  - 0x0C is the half-period;
  - 0x10+4·n is the duty of channel n, for n = 0..11.

  Each register reads back the last value written. Reads of any other address return 0, and writes to any other address change nothing.
- R3: Writing the enable, half-period or duty registers does not change any output until the matching commit bit has been set and the next boundary has passed.
- R4: The commit bits are in the configuration register:
  - bit 0 commits the enable word;
  - bit 1 commits the half-period;
  - bit 2+n commits the duty of channel n.

  Writing a 1 sets a bit and writing a 0 leaves it unchanged. The register reads back the pending bits, and all of them clear at the next period boundary.
- R5: Committed values are copied to the live generator only on the period boundary.
- R6: Let H be the live half-period and c the live count. Channel n is high while it is enabled and 2·(H−c) ≤ duty[n]. This gives a high time of duty rounded down to an even number of units, centered in the period. A duty of 0 keeps the output low. A duty of 2·H or more keeps it high for the whole period.
- R7: A channel whose live enable bit is 0 drives its output low. A newly enabled channel starts at the beginning of a period.
- R8: The sweep count advances only on cycles where `tick` is 1. With `tick` held low, all outputs hold their values.
- R9: One period lasts 2·H ticks, and the period is shared by all channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-unit clock enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 12 | PWM outputs, bit n is channel n |

## Verification
The bench looks for the points where a wrong design shows up:
- A commit written mid-period: a design that applied it at once would cut the current cycle short.
- A commit bit written back to 0 before the boundary: a design that treated this as a cancel would lose the pending duty.
- An odd duty value and a duty above the full period: an off-by-one in the center compare would give a pulse one unit too wide or a gap in a fully high output.
- Stretches of `tick` held low or pulsed every third cycle: a design that ran its sweep on the raw clock would drift from the reference model.
- A change of half-period: a design that did not reload the count range at the boundary would measure the wrong period.

// File: rtl/pwm12_pkg.sv
package pwm12_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CFG   = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_EN    = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_HALF  = 8'h0C;
    localparam int                DUTY_BASE = 16;

    // Bit positions inside the configuration register
    localparam int CB_EN   = 0;
    localparam int CB_HALF = 1;
    localparam int CB_DUTY = 2;

    typedef enum logic [0:0] {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } sweep_e;

    function automatic logic [ADDR_W-1:0] duty_adr(input int n);
        return ADDR_W'(DUTY_BASE + 4 * n);
    endfunction

endpackage

// File: rtl/pwm12_regs.sv
module pwm12_regs
    import pwm12_pkg::*;
#(
    parameter int          NCH      = 12,
    parameter int          PW       = 32,
    parameter int          DW       = 32,
    parameter logic [31:0] HALF_RST = 32'd5000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    input  logic                    boundary,
    output logic [31:0]             bus_rdata,
    output logic [NCH-1:0]          en_sh,
    output logic [PW-1:0]           half_sh,
    output logic [NCH-1:0][DW-1:0]  duty_sh,
    output logic [NCH+1:0]          pend
);

    localparam int CW = NCH + 2;

    logic wr_cfg, wr_en, wr_half;

    assign wr_cfg  = bus_wr && (bus_addr == ADR_CFG);
    assign wr_en   = bus_wr && (bus_addr == ADR_EN);
    assign wr_half = bus_wr && (bus_addr == ADR_HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_sh   <= '0;
            half_sh <= PW'(HALF_RST);
            pend    <= '0;
        end else begin
            if (wr_en)   en_sh   <= bus_wdata[NCH-1:0];
            if (wr_half) half_sh <= bus_wdata[PW-1:0];
            pend <= (boundary ? '0 : pend) | (wr_cfg ? bus_wdata[CW-1:0] : '0);
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_duty
        logic [DW-1:0] dq;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dq <= '0;
            else if (bus_wr && (bus_addr == duty_adr(n)))
                dq <= bus_wdata[DW-1:0];
        end
        assign duty_sh[n] = dq;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CFG)  bus_rdata = 32'(pend);
        if (bus_addr == ADR_EN)   bus_rdata = 32'(en_sh);
        if (bus_addr == ADR_HALF) bus_rdata = 32'(half_sh);
        for (int n = 0; n < NCH; n++)
            if (bus_addr == duty_adr(n)) bus_rdata = 32'(duty_sh[n]);
    end

endmodule

// File: rtl/pwm12_timebase.sv
module pwm12_timebase
    import pwm12_pkg::*;
#(
    parameter int          PW       = 32,
    parameter logic [31:0] HALF_RST = 32'd5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ld_half,
    input  logic [PW-1:0] half_sh,
    output logic [PW-1:0] half_act,
    output logic [PW-1:0] cnt,
    output logic          boundary
);

    sweep_e        state_q, state_d;
    logic [PW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RISE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        boundary = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_RISE: begin
                    if (cnt_q == half_act - PW'(1)) state_d = ST_FALL;
                    else                            cnt_d   = cnt_q + PW'(1);
                end
                ST_FALL: begin
                    if (cnt_q == '0) begin
                        state_d  = ST_RISE;
                        boundary = 1'b1;
                    end else begin
                        cnt_d = cnt_q - PW'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   half_act <= PW'(HALF_RST);
        else if (boundary && ld_half) half_act <= half_sh;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/pwm12_chan.sv
module pwm12_chan #(
    parameter int PW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          ld_en,
    input  logic          ld_duty,
    input  logic          en_sh,
    input  logic [DW-1:0] duty_sh,
    input  logic [PW-1:0] half_act,
    input  logic [PW-1:0] cnt,
    output logic          run,
    output logic          pwm
);

    localparam int CMPW = (PW + 1 > DW) ? PW + 1 : DW;

    logic [DW-1:0]   duty_q;
    logic [PW-1:0]   gap;
    logic [CMPW-1:0] dist2, dref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
            run    <= 1'b0;
        end else if (boundary) begin
            if (ld_duty) duty_q <= duty_sh;
            if (ld_en)   run    <= en_sh;
        end
    end

    assign gap   = half_act - cnt;
    assign dist2 = CMPW'({gap, 1'b0});
    assign dref  = CMPW'(duty_q);
    assign pwm   = run & (dist2 <= dref);

endmodule

// File: rtl/pwm12_ctrl.sv
module pwm12_ctrl
    import pwm12_pkg::*;
#(
    parameter int          NCH      = 12,
    parameter int          PW       = 32,
    parameter int          DW       = 32,
    parameter logic [31:0] HALF_RST = 32'd5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    logic [NCH-1:0]         en_sh;
    logic [PW-1:0]          half_sh;
    logic [NCH-1:0][DW-1:0] duty_sh;
    logic [NCH+1:0]         pend;
    logic [PW-1:0]          half_act;
    logic [PW-1:0]          cnt;
    logic                   boundary;
    logic [NCH-1:0]         run;

    pwm12_regs #(.NCH(NCH), .PW(PW), .DW(DW), .HALF_RST(HALF_RST)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .boundary  (boundary),
        .bus_rdata (bus_rdata),
        .en_sh     (en_sh),
        .half_sh   (half_sh),
        .duty_sh   (duty_sh),
        .pend      (pend)
    );

    pwm12_timebase #(.PW(PW), .HALF_RST(HALF_RST)) tb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ld_half  (pend[CB_HALF]),
        .half_sh  (half_sh),
        .half_act (half_act),
        .cnt      (cnt),
        .boundary (boundary)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pwm12_chan #(.PW(PW), .DW(DW)) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .boundary (boundary),
            .ld_en    (pend[CB_EN]),
            .ld_duty  (pend[CB_DUTY + n]),
            .en_sh    (en_sh[n]),
            .duty_sh  (duty_sh[n]),
            .half_act (half_act),
            .cnt      (cnt),
            .run      (run[n]),
            .pwm      (pwm_out[n])
        );
    end

endmodule

// File: rtl/pwm12_ctrl_chk.sv
module pwm12_ctrl_chk #(
    parameter int NCH = 12,
    parameter int PW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick,
    input logic           bus_wr,
    input logic [7:0]     bus_addr,
    input logic [NCH-1:0] pwm_out,
    input logic [NCH-1:0] run,
    input logic [NCH+1:0] pend,
    input logic [PW-1:0]  cnt,
    input logic [PW-1:0]  half_act,
    input logic           boundary
);

    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out & ~run) == '0);

    // R5
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(run));

    // R5
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(half_act));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R8
    bnd_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> tick);

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !(bus_wr && bus_addr == 8'h00)) |=> pend == '0);

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_act != '0) |-> cnt < half_act);

endmodule

bind pwm12_ctrl pwm12_ctrl_chk #(.NCH(NCH), .PW(PW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .pwm_out  (pwm_out),
    .run      (run),
    .pend     (pend),
    .cnt      (cnt),
    .half_act (half_act),
    .boundary (boundary)
);

// File: tb/pwm12_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm12_ctrl_tb_top;

    localparam int NCH = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;
    int tick_mode = 1;

    always #2.5 clk = ~clk;

    pwm12_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // ---------------- reference model ----------------
    longint m_half, m_ahalf, m_p;
    longint m_duty [NCH];
    longint m_aduty[NCH];
    bit [NCH-1:0] m_en, m_run;
    bit [NCH+1:0] m_pend;
    bit m_bnd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_half = 5000; m_ahalf = 5000; m_p = 0;
            m_en = '0; m_run = '0; m_pend = '0; m_bnd = 1'b0;
            for (int n = 0; n < NCH; n++) begin m_duty[n] = 0; m_aduty[n] = 0; end
        end else begin
            m_bnd = 1'b0;
            if (tick) begin
                if (m_p == 2 * m_ahalf - 1) begin
                    m_bnd = 1'b1;
                    m_p = 0;
                    if (m_pend[1]) m_ahalf = m_half;
                    if (m_pend[0]) m_run = m_en;
                    for (int n = 0; n < NCH; n++)
                        if (m_pend[n+2]) m_aduty[n] = m_duty[n];
                    m_pend = '0;
                end else begin
                    m_p = m_p + 1;
                end
            end
            if (bus_wr) begin
                if (bus_addr == 8'h00)      m_pend = m_pend | bus_wdata[NCH+1:0];
                else if (bus_addr == 8'h08) m_en = bus_wdata[NCH-1:0];
                else if (bus_addr == 8'h0C) m_half = longint'(bus_wdata);
                else if (bus_addr >= 8'h10 && bus_addr < 8'h40 && bus_addr[1:0] == 2'b00)
                    m_duty[(int'(bus_addr) - 16) / 4] = longint'(bus_wdata);
            end
        end
    end

    function automatic bit [NCH-1:0] m_out();
        bit [NCH-1:0] r;
        longint v;
        v = (m_p < m_ahalf) ? (m_ahalf - m_p) : (m_p - m_ahalf + 1);
        for (int n = 0; n < NCH; n++) r[n] = m_run[n] && (2 * v <= m_aduty[n]);
        return r;
    endfunction

    function automatic longint m_read(input logic [7:0] a);
        if (a == 8'h00) return longint'(m_pend);
        if (a == 8'h08) return longint'(m_en);
        if (a == 8'h0C) return m_half;
        if (a >= 8'h10 && a < 8'h40 && a[1:0] == 2'b00) return m_duty[(int'(a) - 16) / 4];
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(pwm_out == m_out(), "R6 waveform vs model", longint'(pwm_out), longint'(m_out()));
            chk(longint'(bus_rdata) == m_read(bus_addr), "R2 readback vs model",
                longint'(bus_rdata), m_read(bus_addr));
        end
    end

    // Tick driver
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            ph = (ph + 1) % 3;
            if (tick_mode == 0)      tick = 1'b0;
            else if (tick_mode == 1) tick = 1'b1;
            else                     tick = (ph == 0);
        end
    end

    // ---------------- tasks ----------------
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [7:0] a, input longint exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        chk(longint'(bus_rdata) == exp, tag, longint'(bus_rdata), exp);
    endtask

    task automatic wait_boundary();
        int g = 0;
        @(negedge clk);
        while (!m_bnd && g < 20000) begin @(negedge clk); g++; end
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        int g = 0;
        logic prev;
        per = 0; hi = 0;
        @(negedge clk);
        while (pwm_out[ch] !== 1'b0 && g < 500) begin @(negedge clk); g++; end
        while (pwm_out[ch] !== 1'b1 && g < 500) begin @(negedge clk); g++; end
        per = 1; hi = 1; prev = 1'b1;
        while (g < 500) begin
            @(negedge clk); g++;
            if (!prev && pwm_out[ch]) break;
            per++;
            if (pwm_out[ch]) hi++;
            prev = pwm_out[ch];
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int per, hi;
        logic [NCH-1:0] snap;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(pwm_out == '0, "R1 outputs low", longint'(pwm_out), 0);
        read_chk(8'h00, 0, "R1 cfg reset");
        read_chk(8'h08, 0, "R1 enable reset");
        read_chk(8'h0C, 5000, "R1 half reset");
        read_chk(8'h10, 0, "R1 duty0 reset");
        read_chk(8'h3C, 0, "R1 duty11 reset");

        // R2 map and readback
        bus_write(8'h24, 32'd77);
        read_chk(8'h24, 77, "R2 duty5 readback");
        bus_write(8'h04, 32'hFFFF);
        read_chk(8'h04, 0, "R2 unmapped read");
        read_chk(8'h40, 0, "R2 beyond map read");

        // Program: half 8 (period 16)
        bus_write(8'h0C, 32'd8);
        bus_write(8'h10, 32'd6);   // ch0
        bus_write(8'h14, 32'd0);   // ch1 zero duty
        bus_write(8'h18, 32'd16);  // ch2 full
        bus_write(8'h1C, 32'd7);   // ch3 odd
        bus_write(8'h08, 32'h02F);
        // R3 nothing applied before commit
        repeat (20) @(negedge clk);
        chk(pwm_out == '0, "R3 no effect before commit", longint'(pwm_out), 0);
        bus_write(8'h00, 32'h3FFF);
        read_chk(8'h00, 32'h3FFF, "R4 pending visible");
        // R5 not applied before boundary
        chk(pwm_out == '0, "R5 held until boundary", longint'(pwm_out), 0);
        wait_boundary();
        read_chk(8'h00, 0, "R4 commits self-clear");

        // R9 / R6 shape
        measure(0, per, hi);
        chk(per == 16, "R9 period 2*half", per, 16);
        chk(hi == 6, "R6 ch0 high time", hi, 6);
        measure(3, per, hi);
        chk(hi == 6, "R6 odd duty rounds down", hi, 6);
        @(negedge clk);
        chk(pwm_out[2] == 1'b1, "R6 full duty high", pwm_out[2], 1);
        chk(pwm_out[5] == 1'b1, "R6 over-range duty high", pwm_out[5], 1);
        repeat (16) begin
            @(negedge clk);
            chk(pwm_out[1] == 1'b0, "R6 zero duty low", pwm_out[1], 0);
        end

        // R3 uncommitted duty ignored; R4 writing zero keeps pending
        bus_write(8'h10, 32'd10);
        repeat (40) @(negedge clk);
        measure(0, per, hi);
        chk(hi == 6, "R3 uncommitted duty ignored", hi, 6);
        bus_write(8'h00, 32'h004);
        bus_write(8'h00, 32'h000);
        read_chk(8'h00, 32'h004, "R4 zero write keeps pending");
        wait_boundary();
        measure(0, per, hi);
        chk(hi == 10, "R4 committed duty0 applied", hi, 10);

        // R7 disable channel 0
        bus_write(8'h08, 32'h02E);
        bus_write(8'h00, 32'h001);
        wait_boundary();
        repeat (32) begin
            @(negedge clk);
            chk(pwm_out[0] == 1'b0, "R7 disabled low", pwm_out[0], 0);
        end

        // R8 tick gating
        tick_mode = 0;
        repeat (3) @(negedge clk);
        snap = pwm_out;
        repeat (20) begin
            @(negedge clk);
            chk(pwm_out == snap, "R8 hold without tick", longint'(pwm_out), longint'(snap));
        end
        tick_mode = 2;
        repeat (200) @(negedge clk);
        tick_mode = 1;

        // R9 period change
        bus_write(8'h0C, 32'd5);
        bus_write(8'h00, 32'h002);
        wait_boundary();
        read_chk(8'h0C, 5, "R2 half readback");
        measure(3, per, hi);
        chk(per == 10, "R9 new period", per, 10);
        chk(hi == 6, "R6 high time after period change", hi, 6);

        // R7 re-enable starts at boundary
        bus_write(8'h08, 32'h02F);
        bus_write(8'h00, 32'h001);
        repeat (60) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule